// File: doc/BRIEF.md
# Three-Address Integer Execute Unit

This block is the execute stage of a 32-bit load/store processor. Each cycle it takes a first operand, a second operand built from the instruction, and an operation code. It returns a 32-bit result combinationally in the same cycle. The second operand comes either from the register file or from a short signed constant in the instruction, and one instruction bit selects between them. The block covers twelve arithmetic, logic and shift operations, plus an operation that loads a constant into the upper bits of the result.

The unit also holds a registered four-bit condition-code word. This word changes at a clock edge only when the instruction's set-codes bit asks for it. The carry-chained add and subtract forms read the stored carry. Register index zero reads as the value zero for both operands. Because of this, move, compare, negate and clear need no opcodes of their own: they are add and subtract forms with the zero register as an operand.

Top module: `iexec_unit`

## Requirements
- R1: When `imm_sel` is 1, the second operand S2 is `imm_field` sign-extended from bit 12 to 32 bits. When `imm_sel` is 0, S2 is `src2_data`, except that it is zero when `imm_field[4:0]` (the register index) is 0.
- R2: The first operand A is zero when `src1_idx` is 0, whatever `src1_data` holds. Otherwise A is `src1_data`.
- R3: `op_sel` 0 (add) gives A+S2. Code 1 (add with carry) gives A+S2+Cstored. The C flag written is the carry out of bit 31.
- R4: Code 2 (subtract) gives A−S2, computed as A+~S2+1. Code 3 (subtract with carry) gives A+~S2+Cstored. C is the carry out of bit 31, so 1 means no borrow.
- R5: Code 4 (reverse subtract) gives S2−A, computed as S2+~A+1. Code 5 (reverse subtract with carry) gives S2+~A+Cstored. C follows the same rule as R4.
- R6: Codes 6, 7 and 8 give A AND S2, A OR S2 and A XOR S2.
- R7: Codes 9, 10 and 11 shift A by S2[4:0]. Code 9 shifts left. Code 10 shifts right with zero fill. Code 11 shifts right with sign fill.
- R8: Code 12 (load high) gives `y_field` in bits 31:13 and zero in bits 12:0.
- R9: The flag register `flags` is written at a rising clock edge only when `scc` is 1. When `scc` is 0 it holds its value.
- R10: The written flags are `flags[3]`=N (result bit 31), `flags[2]`=Z (result equals zero) and `flags[1]`=V. V is the signed overflow of the addition actually performed (both addends share a sign that the sum does not).
- R11: Logic, shift and load-high operations with `scc` set write V=0 and C=0.
- R12: Codes 13 to 15 give a zero result and leave the flags unchanged, even when `scc` is 1.
- R13: A synchronous active-high `rst` clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| src1_idx | input | 5 | Register index of the first operand (0 reads as zero) |
| src1_data | input | 32 | Register data of the first operand |
| src2_data | input | 32 | Register data of the second operand |
| imm_field | input | 13 | Second-operand field: constant, or register index in bits 4:0 |
| imm_sel | input | 1 | 1 selects the constant, 0 selects the register |
| y_field | input | 19 | Long constant for load high |
| op_sel | input | 4 | Operation code |
| scc | input | 1 | Set-condition-codes bit |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered N, Z, V, C |

## Verification
The hardest case to reach from the ports is a carry-chained subtract whose result depends on a stored carry of a known value. Getting there needs an earlier instruction with `scc` set that left C at a chosen value, with no flag-writing instruction in between. The directed part of the stimulus builds these chains on purpose: an equal compare followed by a reverse subtract with carry, and a borrowing subtract followed by a subtract with carry. The random part keeps a running model of the flag word and mixes in instructions with `scc` clear and undefined codes. These instructions must not disturb the stored carry.

// File: rtl/iexec_pkg.sv
package iexec_pkg;
    localparam int XLEN    = 32;
    localparam int IMM_W   = 13;
    localparam int HI_W    = 19;
    localparam int RIDX_W  = 5;
    localparam int OP_W    = 4;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int LO_W    = XLEN - HI_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBC  = 4'd3,
        OP_RSUB  = 4'd4,
        OP_RSUBC = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_SLL   = 4'd9,
        OP_SRL   = 4'd10,
        OP_SRA   = 4'd11,
        OP_LDHI  = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } opnd_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] x);
        return {{(XLEN-IMM_W){x[IMM_W-1]}}, x};
    endfunction

    function automatic logic op_valid(input logic [OP_W-1:0] op);
        return op <= OP_LDHI;
    endfunction

    function automatic logic op_arith(input logic [OP_W-1:0] op);
        return op <= OP_RSUBC;
    endfunction
endpackage

// File: rtl/iexec_opnd.sv
module iexec_opnd
    import iexec_pkg::*;
(
    input  logic [RIDX_W-1:0] src1_idx,
    input  logic [XLEN-1:0]   src1_data,
    input  logic [XLEN-1:0]   src2_data,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic              imm_sel,
    output opnd_t             opnd
);
    logic src1_zero;
    logic src2_zero;

    assign src1_zero = (src1_idx == '0);
    assign src2_zero = (imm_field[RIDX_W-1:0] == '0);

    always_comb begin
        opnd.a = src1_zero ? '0 : src1_data;
        if (imm_sel)
            opnd.b = sext_imm(imm_field);
        else
            opnd.b = src2_zero ? '0 : src2_data;
    end
endmodule

// File: rtl/iexec_alu.sv
module iexec_alu
    import iexec_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  opnd_t            opnd,
    input  logic [HI_W-1:0]  y_field,
    input  logic             c_in,
    output logic [XLEN-1:0]  res,
    output logic             ovf,
    output logic             cout
);
    logic [XLEN-1:0] add_x;
    logic [XLEN-1:0] add_y;
    logic            add_ci;
    logic [XLEN:0]   add_sum;
    logic [SHAMT_W-1:0] shamt;

    assign shamt = opnd.b[SHAMT_W-1:0];

    always_comb begin
        add_x  = opnd.a;
        add_y  = opnd.b;
        add_ci = 1'b0;
        unique case (op)
            OP_ADDC:  add_ci = c_in;
            OP_SUB:   begin add_y = ~opnd.b; add_ci = 1'b1; end
            OP_SUBC:  begin add_y = ~opnd.b; add_ci = c_in; end
            OP_RSUB:  begin add_x = opnd.b; add_y = ~opnd.a; add_ci = 1'b1; end
            OP_RSUBC: begin add_x = opnd.b; add_y = ~opnd.a; add_ci = c_in; end
            default:  ;
        endcase
    end

    assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{XLEN{1'b0}}, add_ci};
    assign cout    = add_sum[XLEN];
    assign ovf     = (add_x[XLEN-1] == add_y[XLEN-1]) && (add_sum[XLEN-1] != add_x[XLEN-1]);

    always_comb begin
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB, OP_RSUBC:
                res = add_sum[XLEN-1:0];
            OP_AND:  res = opnd.a & opnd.b;
            OP_OR:   res = opnd.a | opnd.b;
            OP_XOR:  res = opnd.a ^ opnd.b;
            OP_SLL:  res = opnd.a << shamt;
            OP_SRL:  res = opnd.a >> shamt;
            OP_SRA:  res = $unsigned($signed(opnd.a) >>> shamt);
            OP_LDHI: res = {y_field, {LO_W{1'b0}}};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/iexec_ccr.sv
module iexec_ccr
    import iexec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  cc_t  nxt,
    output cc_t  cc
);
    always_ff @(posedge clk) begin
        if (rst)
            cc <= '0;
        else if (upd)
            cc <= nxt;
    end
endmodule

// File: rtl/iexec_unit.sv
module iexec_unit
    import iexec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        src1_idx,
    input  logic [31:0]       src1_data,
    input  logic [31:0]       src2_data,
    input  logic [12:0]       imm_field,
    input  logic              imm_sel,
    input  logic [18:0]       y_field,
    input  logic [3:0]        op_sel,
    input  logic              scc,
    output logic [31:0]       result,
    output logic [3:0]        flags
);
    opnd_t     opnd;
    logic      alu_ovf;
    logic      alu_cout;
    logic      upd;
    cc_t       cc_now;
    cc_t       cc_nxt;

    iexec_opnd u_opnd (
        .src1_idx  (src1_idx),
        .src1_data (src1_data),
        .src2_data (src2_data),
        .imm_field (imm_field),
        .imm_sel   (imm_sel),
        .opnd      (opnd)
    );

    iexec_alu u_alu (
        .op      (op_sel),
        .opnd    (opnd),
        .y_field (y_field),
        .c_in    (cc_now.c),
        .res     (result),
        .ovf     (alu_ovf),
        .cout    (alu_cout)
    );

    assign upd = scc && op_valid(op_sel);

    always_comb begin
        cc_nxt.n = result[XLEN-1];
        cc_nxt.z = (result == '0);
        cc_nxt.v = op_arith(op_sel) ? alu_ovf  : 1'b0;
        cc_nxt.c = op_arith(op_sel) ? alu_cout : 1'b0;
    end

    iexec_ccr u_ccr (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .nxt (cc_nxt),
        .cc  (cc_now)
    );

    assign flags = cc_now;

    AST_IMM_SEXT: assert property (@(posedge clk) disable iff (rst)
        (imm_sel && op_sel == OP_ADD && src1_idx == '0) |-> result == sext_imm(imm_field)); // R1
    AST_SRC1_ZERO: assert property (@(posedge clk) disable iff (rst)
        (src1_idx == '0 && imm_sel && imm_field == '0 && op_sel == OP_OR) |-> result == '0); // R2
    AST_LDHI_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_LDHI) |-> (result[12:0] == '0 && result[31:13] == y_field)); // R8
    AST_HOLD_NO_SCC: assert property (@(posedge clk) disable iff (rst)
        !scc |=> $stable(flags)); // R9
    AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (scc && op_sel <= OP_LDHI) |=> flags[2] == ($past(result) == '0)); // R10
    AST_N_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (scc && op_sel <= OP_LDHI) |=> flags[3] == $past(result[31])); // R10
    AST_LOGIC_VC: assert property (@(posedge clk) disable iff (rst)
        (scc && op_sel >= OP_AND && op_sel <= OP_LDHI) |=> flags[1:0] == 2'b00); // R11
    AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_sel > OP_LDHI) |-> result == '0); // R12
    AST_BAD_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_sel > OP_LDHI) |=> $stable(flags)); // R12
endmodule

// File: tb/iexec_unit_tb.sv
module iexec_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  src1_idx;
    logic [31:0] src1_data;
    logic [31:0] src2_data;
    logic [12:0] imm_field;
    logic        imm_sel;
    logic [18:0] y_field;
    logic [3:0]  op_sel;
    logic        scc;
    logic [31:0] result;
    logic [3:0]  flags;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] mflags;

    always #(CLK_P/2) clk = ~clk;

    iexec_unit dut_i (
        .clk(clk), .rst(rst), .src1_idx(src1_idx), .src1_data(src1_data),
        .src2_data(src2_data), .imm_field(imm_field), .imm_sel(imm_sel),
        .y_field(y_field), .op_sel(op_sel), .scc(scc), .result(result), .flags(flags)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:        return "R3";
            4'd2, 4'd3:        return "R4";
            4'd4, 4'd5:        return "R5";
            4'd6, 4'd7, 4'd8:  return "R6";
            4'd9, 4'd10, 4'd11: return "R7";
            4'd12:             return "R8";
            default:           return "R12";
        endcase
    endfunction

    // model: returns {result, n, z, v, c, writes}
    function automatic logic [36:0] model(input logic [4:0] i1, input logic [31:0] d1,
        input logic [31:0] d2, input logic [12:0] imf, input logic isel,
        input logic [18:0] y, input logic [3:0] op, input logic cst);
        logic [31:0] a, b, r, x, yy;
        logic [32:0] s;
        logic ci, v, c, ar;
        a  = (i1 == 5'd0) ? 32'd0 : d1;
        b  = isel ? {{19{imf[12]}}, imf} : ((imf[4:0] == 5'd0) ? 32'd0 : d2);
        x = a; yy = b; ci = 1'b0; ar = 1'b1;
        case (op)
            4'd0: ;
            4'd1: ci = cst;
            4'd2: begin yy = ~b; ci = 1'b1; end
            4'd3: begin yy = ~b; ci = cst; end
            4'd4: begin x = b; yy = ~a; ci = 1'b1; end
            4'd5: begin x = b; yy = ~a; ci = cst; end
            default: ar = 1'b0;
        endcase
        s = {1'b0, x} + {1'b0, yy} + {32'd0, ci};
        case (op)
            4'd6:  r = a & b;
            4'd7:  r = a | b;
            4'd8:  r = a ^ b;
            4'd9:  r = a << b[4:0];
            4'd10: r = a >> b[4:0];
            4'd11: r = $unsigned($signed(a) >>> b[4:0]);
            4'd12: r = {y, 13'd0};
            4'd13, 4'd14, 4'd15: r = 32'd0;
            default: r = s[31:0];
        endcase
        v = ar && (x[31] == yy[31]) && (s[31] != x[31]);
        c = ar && s[32];
        return {r, r[31], (r == 32'd0), v, c, (op <= 4'd12)};
    endfunction

    task automatic apply(input logic [4:0] i1, input logic [31:0] d1, input logic [31:0] d2,
        input logic [12:0] imf, input logic isel, input logic [18:0] y,
        input logic [3:0] op, input logic sc, input string tag);
        logic [36:0] m;
        @(negedge clk);
        src1_idx = i1; src1_data = d1; src2_data = d2; imm_field = imf;
        imm_sel = isel; y_field = y; op_sel = op; scc = sc;
        m = model(i1, d1, d2, imf, isel, y, op, mflags[0]);
        #1;
        chk(result == m[36:5], tag, result, m[36:5]);
        @(posedge clk);
        #1;
        if (sc && m[0]) mflags = m[4:1];
        chk(flags == mflags, sc ? "R10 flags" : "R9 flags held", {28'd0, flags}, {28'd0, mflags});
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; src1_idx = 0; src1_data = 0; src2_data = 0; imm_field = 0;
        imm_sel = 0; y_field = 0; op_sel = 0; scc = 0;
        mflags = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        chk(flags == 4'd0, "R13 reset", {28'd0, flags}, 32'd0);
        // set flags non-zero, then reset again
        rst = 1'b0;
        apply(5'd1, 32'h8000_0000, 32'h8000_0000, 13'd2, 1'b0, 19'd0, 4'd0, 1'b1, "R3 ovf add");
        @(negedge clk); rst = 1'b1; @(posedge clk); #1; mflags = 4'd0;
        chk(flags == 4'd0, "R13 reset clears", {28'd0, flags}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // R1: negative immediate sign extension via add with R0
        apply(5'd0, 32'hDEAD_BEEF, 32'h0, 13'h1FFF, 1'b1, 19'd0, 4'd0, 1'b1, "R1 sext imm");
        apply(5'd0, 32'h0, 32'h1234_5678, 13'h0FFF, 1'b1, 19'd0, 4'd0, 1'b1, "R1 positive imm");
        // R1: register index zero for src2
        apply(5'd3, 32'h0000_0055, 32'hFFFF_FFFF, 13'h1FE0, 1'b0, 19'd0, 4'd7, 1'b1, "R1 src2 r0");
        apply(5'd3, 32'h0000_0055, 32'hFFFF_0000, 13'h0004, 1'b0, 19'd0, 4'd7, 1'b1, "R1 src2 reg");
        // R2: src1 index zero
        apply(5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 13'd0, 1'b1, 19'd0, 4'd7, 1'b1, "R2 src1 r0");
        // R3: signed overflow add, then add-with-carry using stored C
        apply(5'd1, 32'h7FFF_FFFF, 32'h0, 13'd1, 1'b1, 19'd0, 4'd0, 1'b1, "R3 overflow");
        apply(5'd1, 32'hFFFF_FFFF, 32'h0, 13'd1, 1'b1, 19'd0, 4'd0, 1'b1, "R3 carry out");
        apply(5'd1, 32'h0000_0010, 32'h0, 13'd1, 1'b1, 19'd0, 4'd1, 1'b1, "R3 addc cin");
        // R4: equal compare, borrow, subc chain
        apply(5'd2, 32'd77, 32'd77, 13'd5, 1'b0, 19'd0, 4'd2, 1'b1, "R4 equal");
        apply(5'd2, 32'd3, 32'd4, 13'd5, 1'b0, 19'd0, 4'd2, 1'b1, "R4 borrow");
        apply(5'd2, 32'd10, 32'd4, 13'd5, 1'b0, 19'd0, 4'd3, 1'b1, "R4 subc after borrow");
        // R5: reverse subtract; negate via R0 source
        apply(5'd2, 32'd5, 32'd0, 13'd0, 1'b1, 19'd0, 4'd4, 1'b1, "R5 negate");
        apply(5'd2, 32'd9, 32'd9, 13'd7, 1'b0, 19'd0, 4'd2, 1'b1, "R5 setup C");
        apply(5'd2, 32'd4, 32'd0, 13'd20, 1'b1, 19'd0, 4'd5, 1'b1, "R5 rsubc");
        // R6
        apply(5'd4, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 13'd9, 1'b0, 19'd0, 4'd6, 1'b1, "R6 and");
        apply(5'd4, 32'hF0F0_F0F0, 32'h0, 13'h1FFF, 1'b1, 19'd0, 4'd8, 1'b1, "R6 xor not");
        // R7: amounts beyond 31 use only low bits
        apply(5'd4, 32'h8000_0001, 32'h0000_0024, 13'd9, 1'b0, 19'd0, 4'd11, 1'b1, "R7 sra amount 36");
        apply(5'd4, 32'h8000_0001, 32'h0, 13'd31, 1'b1, 19'd0, 4'd10, 1'b1, "R7 srl 31");
        apply(5'd4, 32'h8000_0001, 32'h0, 13'd1, 1'b1, 19'd0, 4'd9, 1'b1, "R7 sll 1");
        // R8 and R11
        apply(5'd1, 32'hFFFF_FFFF, 32'h0, 13'h1FFF, 1'b1, 19'h7_ABCD, 4'd12, 1'b1, "R8 ldhi");
        apply(5'd1, 32'hFFFF_FFFF, 32'h0, 13'd1, 1'b1, 19'd0, 4'd0, 1'b1, "R11 setup C");
        apply(5'd1, 32'h0, 32'h0, 13'd0, 1'b1, 19'd0, 4'd7, 1'b1, "R11 or clears VC");
        // R9: scc clear keeps flags
        apply(5'd1, 32'h7FFF_FFFF, 32'h0, 13'd1, 1'b1, 19'd0, 4'd0, 1'b0, "R9 no scc");
        // R12: undefined codes
        apply(5'd1, 32'h1234, 32'h5678, 13'd3, 1'b0, 19'h1, 4'd13, 1'b1, "R12 code13");
        apply(5'd1, 32'h1234, 32'h5678, 13'd3, 1'b0, 19'h1, 4'd15, 1'b1, "R12 code15");

        for (int k = 0; k < 600; k++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            apply(5'($urandom), $urandom, $urandom, 13'($urandom), 1'($urandom),
                  19'($urandom), op, ($urandom_range(0, 3) != 0), op_tag(op));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule